// File: doc/BRIEF.md
# Receive Lane Polarity Inversion Detector

This block sits on a single receive lane, after symbol decode and alignment. While the link is training, it watches the stream of decoded symbols for training ordered sets. Each set opens with a comma control symbol. The block counts symbol positions from that comma and inspects only the identifier positions, 6 through 15. If every one of those ten symbols arrives bit-complemented, the lane's differential pair is swapped. The block then sets a sticky invert flag, and from that point every data byte it forwards is complemented.

Each lane has its own instance, so the lanes of one link settle their polarity separately. The forwarding path is a single register stage, with the valid and control-symbol flags carried alongside the data. The flag is cleared only by reset or by a retrain pulse. Nothing on the transmit side is involved.

Top module: `lane_pol_detect`

## Requirements
- R1: After a synchronous active-low reset, `pol_inv` and `vld_out` are both 0.
- R2: Outputs lag the inputs by exactly one clock. `vld_out` and `sym_k_out` repeat `sym_vld` and `sym_k`. `sym_out` is `sym_in` XOR 0xFF when `pol_inv` was 1 in the sampling cycle, and `sym_in` unchanged when it was 0.
- R3: A set opened by the comma (control flag 1, byte 0xBC, position 0) sets `pol_inv` if its positions 6 to 15 all carry data byte 0xB5, the complemented TS1 identifier 0x4A. The flag is set one clock after position 15 is sampled.
- R4: A set whose positions 6 to 15 all carry data byte 0xBA, the complemented TS2 identifier 0x45, sets `pol_inv` in the same way.
- R5: If any one of positions 6 to 15 carries the normal identifier instead, `pol_inv` is left unchanged.
- R6: The contents of positions 1 to 5 have no effect on the decision.
- R7: While `train_act` is 0, no set is examined and `pol_inv` cannot become 1.
- R8: Complemented TS1 and TS2 identifiers mixed within one set do not set the flag.
- R9: Cycles with `sym_vld` at 0 do not advance the position count, so gaps inside a set do not stop detection.
- R10: A comma arriving inside a set restarts the count at position 0. The interrupted set cannot set the flag.
- R11: Once set, `pol_inv` stays at 1 through later normal sets. It returns to 0 on the clock after a `retrain` pulse.
- R12: A symbol with the control flag at 1 in positions 6 to 15 never counts as an identifier, whatever its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| retrain | input | 1 | Full-retrain pulse; clears the invert flag |
| train_act | input | 1 | High while link training is in progress |
| sym_vld | input | 1 | Input symbol strobe |
| sym_k | input | 1 | Input symbol is a control symbol |
| sym_in | input | 8 | Decoded input symbol |
| vld_out | output | 1 | Registered strobe |
| sym_k_out | output | 1 | Registered control flag |
| sym_out | output | 8 | Registered symbol, complemented when inverted |
| pol_inv | output | 1 | Latched lane polarity-inversion flag |

## Verification
A wrong position count or a stale run state has two possible effects at the ports. The flag may rise after a set that should not qualify, or it may fail to rise after one that should. Either way `pol_inv` is wrong one clock after position 15, and every later data byte on `sym_out` is then complemented wrongly. The scoreboard compares every forwarded byte, so a flag error shows up within one symbol. The boundary sets are: one wrong identifier, a control symbol among the identifiers, mixed TS1 and TS2 identifiers, a comma inside a set, gaps, training off, and complemented filler. Each of these is followed directly by a flag check.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   typedef enum logic [1:0] {
      ID_NONE   = 2'd0,
      ID_NORMAL = 2'd1,
      ID_INVERT = 2'd2
   } id_kind_e;

   typedef struct packed {
      id_kind_e kind;
      logic     ts2;
   } id_cls_t;
endpackage

// File: rtl/lpd_os_track.sv
module lpd_os_track #(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] COM_SYM = 8'hBC,
   parameter int          ID_FIRST = 6,
   parameter int          ID_LAST  = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          sym_vld,
   input  logic          sym_k,
   input  logic [DW-1:0] sym_in,
   output logic          id_slot,
   output logic          id_first,
   output logic          id_last
);
   localparam int PW = $clog2(ID_LAST + 1);

   logic [PW-1:0] pos_q;
   logic          in_set_q;
   logic          is_com;
   logic          active;

   assign is_com = sym_vld && sym_k && (sym_in == COM_SYM);
   assign active = sym_vld && in_set_q && !is_com;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         pos_q    <= '0;
         in_set_q <= 1'b0;
      end else if (is_com) begin
         pos_q    <= PW'(1);
         in_set_q <= 1'b1;
      end else if (active) begin
         if (pos_q == PW'(ID_LAST)) begin
            in_set_q <= 1'b0;
         end else begin
            pos_q <= pos_q + PW'(1);
         end
      end
   end

   assign id_slot  = active && (pos_q >= PW'(ID_FIRST)) && (pos_q <= PW'(ID_LAST));
   assign id_first = id_slot && (pos_q == PW'(ID_FIRST));
   assign id_last  = id_slot && (pos_q == PW'(ID_LAST));
endmodule

// File: rtl/lpd_id_class.sv
module lpd_id_class
   import lpd_pkg::*;
#(
   parameter int            DW     = 8,
   parameter logic [DW-1:0] TS1_ID = 8'h4A,
   parameter logic [DW-1:0] TS2_ID = 8'h45
) (
   input  logic          sym_k,
   input  logic [DW-1:0] sym_in,
   output id_cls_t       cls
);
   localparam logic [DW-1:0] TS1_INV = ~TS1_ID;
   localparam logic [DW-1:0] TS2_INV = ~TS2_ID;

   always_comb begin
      cls.kind = ID_NONE;
      cls.ts2  = (sym_in == TS2_ID) || (sym_in == TS2_INV);
      if (!sym_k) begin
         if (sym_in == TS1_ID || sym_in == TS2_ID) begin
            cls.kind = ID_NORMAL;
         end else if (sym_in == TS1_INV || sym_in == TS2_INV) begin
            cls.kind = ID_INVERT;
         end
      end
   end
endmodule

// File: rtl/lpd_vote.sv
module lpd_vote
   import lpd_pkg::*;
#(
   parameter bit TYPE_MATCH = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    abort,
   input  logic    wipe,
   input  logic    id_slot,
   input  logic    id_first,
   input  logic    id_last,
   input  id_cls_t cls,
   output logic    pol_flag
);
   logic run_ok_q;
   logic run_ts2_q;
   logic type_ok;
   logic ok_now;

   generate
      if (TYPE_MATCH) begin : g_typed
         assign type_ok = (cls.ts2 == run_ts2_q);
      end else begin : g_untyped
         assign type_ok = 1'b1;
      end
   endgenerate

   assign ok_now = (cls.kind == ID_INVERT) && (id_first || (run_ok_q && type_ok));

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         run_ok_q  <= 1'b0;
         run_ts2_q <= 1'b0;
      end else if (id_slot) begin
         run_ok_q <= ok_now;
         if (id_first) begin
            run_ts2_q <= cls.ts2;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         pol_flag <= 1'b0;
      end else if (id_last && ok_now) begin
         pol_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/lpd_out_stage.sv
module lpd_out_stage #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inv,
   input  logic          sym_vld,
   input  logic          sym_k,
   input  logic [DW-1:0] sym_in,
   output logic          vld_out,
   output logic          sym_k_out,
   output logic [DW-1:0] sym_out
);
   logic [DW-1:0] fixed;

   generate
      for (genvar b = 0; b < DW; b++) begin : g_bit
         assign fixed[b] = sym_in[b] ^ inv;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_out   <= 1'b0;
         sym_k_out <= 1'b0;
         sym_out   <= '0;
      end else begin
         vld_out   <= sym_vld;
         sym_k_out <= sym_k;
         sym_out   <= fixed;
      end
   end
endmodule

// File: rtl/lane_pol_detect.sv
module lane_pol_detect
   import lpd_pkg::*;
#(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] COM_SYM    = 8'hBC,
   parameter logic [DW-1:0] TS1_ID     = 8'h4A,
   parameter logic [DW-1:0] TS2_ID     = 8'h45,
   parameter int            ID_FIRST   = 6,
   parameter int            ID_LAST    = 15,
   parameter bit            TYPE_MATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          retrain,
   input  logic          train_act,
   input  logic          sym_vld,
   input  logic          sym_k,
   input  logic [DW-1:0] sym_in,
   output logic          vld_out,
   output logic          sym_k_out,
   output logic [DW-1:0] sym_out,
   output logic          pol_inv
);
   localparam int ID_COUNT = ID_LAST - ID_FIRST + 1;

   generate
      if (ID_FIRST < 1 || ID_COUNT < 1) begin : g_bad_window
         $error("identifier window must follow the comma and be non-empty");
      end
      if (DW < 2) begin : g_bad_width
         $error("symbol width too small");
      end
      if (TS1_ID == TS2_ID || TS1_ID == ~TS2_ID) begin : g_bad_ids
         $error("identifier codes must be distinguishable");
      end
   endgenerate

   logic    abort;
   logic    id_slot;
   logic    id_first;
   logic    id_last;
   id_cls_t cls;

   assign abort = retrain || !train_act;

   lpd_os_track #(
      .DW(DW), .COM_SYM(COM_SYM), .ID_FIRST(ID_FIRST), .ID_LAST(ID_LAST)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .abort(abort),
      .sym_vld(sym_vld), .sym_k(sym_k), .sym_in(sym_in),
      .id_slot(id_slot), .id_first(id_first), .id_last(id_last)
   );

   lpd_id_class #(
      .DW(DW), .TS1_ID(TS1_ID), .TS2_ID(TS2_ID)
   ) u_class (
      .sym_k(sym_k), .sym_in(sym_in), .cls(cls)
   );

   lpd_vote #(
      .TYPE_MATCH(TYPE_MATCH)
   ) u_vote (
      .clk(clk), .rst_n(rst_n), .abort(abort), .wipe(retrain),
      .id_slot(id_slot), .id_first(id_first), .id_last(id_last),
      .cls(cls), .pol_flag(pol_inv)
   );

   lpd_out_stage #(
      .DW(DW)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .inv(pol_inv),
      .sym_vld(sym_vld), .sym_k(sym_k), .sym_in(sym_in),
      .vld_out(vld_out), .sym_k_out(sym_k_out), .sym_out(sym_out)
   );
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker #(
   parameter int            DW     = 8,
   parameter logic [DW-1:0] TS1_ID = 8'h4A,
   parameter logic [DW-1:0] TS2_ID = 8'h45
) (
   input logic          clk,
   input logic          rst_n,
   input logic          retrain,
   input logic          train_act,
   input logic          sym_vld,
   input logic          sym_k,
   input logic [DW-1:0] sym_in,
   input logic          vld_out,
   input logic          sym_k_out,
   input logic [DW-1:0] sym_out,
   input logic          pol_inv
);
   logic up;
   always_ff @(posedge clk) up <= rst_n;

   AST_RETRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      retrain |=> !pol_inv); // R11
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pol_inv && !retrain |=> pol_inv); // R11
   AST_VLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      up |-> vld_out == $past(sym_vld)); // R2
   AST_DATA_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      up && $past(sym_vld) |-> sym_k_out == $past(sym_k)
         && sym_out == ($past(sym_in) ^ {DW{$past(pol_inv)}})); // R2
   AST_SET_IN_TRAINING: assert property (@(posedge clk) disable iff (!rst_n)
      up && $rose(pol_inv) |-> $past(train_act) && $past(sym_vld)); // R7
   AST_SET_ON_INV_ID: assert property (@(posedge clk) disable iff (!rst_n)
      up && $rose(pol_inv) |-> !$past(sym_k)
         && ($past(sym_in) == ~TS1_ID || $past(sym_in) == ~TS2_ID)); // R3
endmodule

bind lane_pol_detect lpd_checker #(.DW(DW), .TS1_ID(TS1_ID), .TS2_ID(TS2_ID)) u_chk (
   .clk(clk), .rst_n(rst_n), .retrain(retrain), .train_act(train_act),
   .sym_vld(sym_vld), .sym_k(sym_k), .sym_in(sym_in), .vld_out(vld_out),
   .sym_k_out(sym_k_out), .sym_out(sym_out), .pol_inv(pol_inv)
);

// File: tb/sim_lane_pol_detect.sv
module sim_lane_pol_detect;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       retrain = 1'b0;
   logic       train_act = 1'b1;
   logic       sym_vld = 1'b0;
   logic       sym_k = 1'b0;
   logic [7:0] sym_in = 8'h00;
   logic       vld_out, sym_k_out, pol_inv;
   logic [7:0] sym_out;

   always #2 clk = ~clk;

   lane_pol_detect u0 (
      .clk(clk), .rst_n(rst_n), .retrain(retrain), .train_act(train_act),
      .sym_vld(sym_vld), .sym_k(sym_k), .sym_in(sym_in), .vld_out(vld_out),
      .sym_k_out(sym_k_out), .sym_out(sym_out), .pol_inv(pol_inv)
   );

   typedef struct {
      logic [7:0] d;
      logic       k;
      logic       v;
      string      req;
   } exp_t;

   exp_t  q[$];
   int    checks = 0;
   int    errors = 0;
   bit    m_inv = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R2";

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (vld_out !== e.v) begin
            errors++;
            $display("FAIL %s vld_out got %0b exp %0b", e.req, vld_out, e.v);
         end else if (e.v && (sym_out !== e.d || sym_k_out !== e.k)) begin
            errors++;
            $display("FAIL %s sym_out/k got %h/%0b exp %h/%0b", e.req, sym_out, sym_k_out, e.d, e.k);
         end
      end
   end

   task automatic send(input logic v, input logic k, input logic [7:0] d);
      exp_t e;
      @(negedge clk);
      sym_vld = v; sym_k = k; sym_in = d;
      e.d = d ^ {8{m_inv}}; e.k = k; e.v = v; e.req = cur_req;
      @(posedge clk);
      q.push_back(e);
   endtask

   task automatic chk_flag(input bit exp, input string req);
      #1;
      checks++;
      if (pol_inv !== exp) begin
         errors++;
         $display("FAIL %s pol_inv got %0b exp %0b", req, pol_inv, exp);
      end
   endtask

   // one ordered set: COM, five fillers, ten identifiers (one may be replaced)
   task automatic send_set(input logic [7:0] id, input logic [7:0] filler, input int bad_idx,
                           input logic [7:0] bad_val, input logic bad_k, input bit gaps);
      send(1'b1, 1'b1, 8'hBC);
      for (int i = 1; i <= 5; i++) send(1'b1, 1'b0, filler);
      for (int i = 0; i < 10; i++) begin
         if (i == bad_idx) send(1'b1, bad_k, bad_val);
         else send(1'b1, 1'b0, id);
         if (gaps && (i % 3 == 1)) send(1'b0, 1'b0, 8'h5A);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      checks++;
      if (pol_inv !== 1'b0 || vld_out !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset pol/vld got %0b/%0b exp 0/0", pol_inv, vld_out);
      end

      cur_req = "R2";
      send_set(8'h4A, 8'h11, -1, 8'h00, 1'b0, 1'b0);
      chk_flag(1'b0, "R2 normal TS1");

      cur_req = "R5";
      send_set(8'hB5, 8'h11, 4, 8'h4A, 1'b0, 1'b0);
      chk_flag(1'b0, "R5 one normal id");

      cur_req = "R12";
      send_set(8'hB5, 8'h11, 9, 8'hB5, 1'b1, 1'b0);
      chk_flag(1'b0, "R12 K in id slot");

      cur_req = "R6";
      send_set(8'h45, 8'hB5, -1, 8'h00, 1'b0, 1'b0);
      chk_flag(1'b0, "R6 inverted filler only");

      cur_req = "R7";
      train_act = 1'b0;
      send_set(8'hB5, 8'h11, -1, 8'h00, 1'b0, 1'b0);
      chk_flag(1'b0, "R7 training off");
      train_act = 1'b1;

      cur_req = "R8";
      send_set(8'hB5, 8'h11, 3, 8'hBA, 1'b0, 1'b0);
      chk_flag(1'b0, "R8 mixed TS1/TS2");

      cur_req = "R10";
      send_set(8'hB5, 8'h11, 4, 8'hBC, 1'b1, 1'b0);
      chk_flag(1'b0, "R10 comma inside set");

      cur_req = "R9";
      send_set(8'hB5, 8'h22, -1, 8'h00, 1'b0, 1'b1);
      chk_flag(1'b1, "R3 R9 inverted TS1 with gaps");
      m_inv = 1'b1;

      cur_req = "R11";
      send_set(8'h4A, 8'h33, -1, 8'h00, 1'b0, 1'b0);
      chk_flag(1'b1, "R11 held after normal set");
      send(1'b1, 1'b0, 8'hC3);
      send(1'b1, 1'b1, 8'hBC);

      @(negedge clk);
      retrain = 1'b1; sym_vld = 1'b0;
      @(posedge clk);
      q.push_back('{d: 8'h00, k: 1'b0, v: 1'b0, req: "R11"});
      chk_flag(1'b0, "R11 retrain clears");
      m_inv = 1'b0;
      @(negedge clk);
      retrain = 1'b0;
      @(posedge clk);
      q.push_back('{d: 8'h00, k: 1'b0, v: 1'b0, req: "R11"});

      cur_req = "R4";
      send_set(8'hBA, 8'hB5, -1, 8'h00, 1'b0, 1'b0);
      chk_flag(1'b1, "R4 R6 inverted TS2");
      m_inv = 1'b1;
      send(1'b1, 1'b0, 8'h0F);
      send(1'b0, 1'b0, 8'h00);

      @(negedge clk);
      rst_n = 1'b0; sym_vld = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (pol_inv !== 1'b0 || vld_out !== 1'b0) begin
         errors++;
         $display("FAIL R1 mid-run reset pol/vld got %0b/%0b exp 0/0", pol_inv, vld_out);
      end
      m_inv = 1'b0;
      cur_req = "R2";
      send(1'b1, 1'b0, 8'hA5);
      send(1'b0, 1'b0, 8'h00);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule